// File: doc/BRIEF.md
# MDIO Management Access Register

This block gives a processor one 32-bit word through which it runs single management transactions on a two-wire PHY management bus. Software writes the word with the request bit set. The block then sends one Clause-22 frame on MDC/MDIO to the PHY and register named in the word. The request bit reads back as 1 while the frame is on the wire and drops to 0 when the frame has finished. On a read, the 16 bits returned by the PHY replace the low half of the word in the same cycle that the request bit clears. Software starts an access and then polls bit 31 until it reads 0.

The word is laid out as follows. Bit 31 is request/acknowledge. Bit 30 selects the direction: 1 is a write and 0 is a read. Bits 25:21 carry the PHY address and bits 20:16 the register address. Bits 15:0 carry the write data, or the read result once the access has finished. Bits 29:26 are stored but have no function. As an example, writing 0xC0A09000 sends the value 0x9000 to register 0 of PHY 5.

The block contains the MDC divider, the frame shifter and the output enable for the shared data line. The register interface is a plain one-cycle write strobe with a read-back bus. The processor may not write a new command while the request bit is set, and the block discards any such write.

Top module: `mdio_acc_engine`

## Requirements
- R1: While reset is asserted and after it is released, reg_rdata reads 0, mdc is low and mdio_oe is low.
- R2: A write strobe with reg_wdata bit 31 = 1 while bit 31 of the word is 0 stores the whole value, and reg_rdata shows it from the next cycle. A frame starts at the same point.
- R3: A write with bit 31 = 0 while idle stores the value but starts no frame: mdc stays low and bit 31 stays 0.
- R4: A write frame (bit 30 = 1) is sent MSB first as 64 bits: a preamble of PREAMBLE_LEN = 32 ones, start 01, opcode 01, PHY address (bits 25:21), register address (bits 20:16), turnaround 10, then data bits 15:0. mdio_oe stays high for all 64 bits, and mdio_o changes only while mdc is low.
- R5: A read frame (bit 30 = 0) uses opcode 10. mdio_oe stays high through the register address and is low for the two turnaround bits and the 16 data bits, which are frame positions 46 to 63.
- R6: On a read, mdio_i is sampled on the rising mdc edges of the 16 data bits, MSB first. The result appears in bits 15:0 in the cycle that bit 31 clears, and bits 30:16 keep their values.
- R7: Bit 31 returns to 0 after the 64th bit period. After a write frame the rest of the word is unchanged.
- R8: A write strobe while bit 31 is set has no effect on the word or on the frame in progress.
- R9: mdc has a period of CLK_DIV clock cycles with a high phase of CLK_DIV/2 cycles. mdc toggles only while bit 31 is set. When idle, mdc is low and mdio_oe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | One-cycle write strobe for the access word |
| reg_wdata | input | 32 | Value written to the access word |
| reg_rdata | output | 32 | Current access word; bit 31 is busy/acknowledge |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Data driven onto the management data line |
| mdio_oe | output | 1 | Output enable for the tri-state management data line |
| mdio_i | input | 1 | Management data line as seen by the block |

## Verification
The checks assume that CLK_DIV is even and at least 2. They also assume that reg_wr is a single-cycle strobe and that the PHY changes mdio_i only while mdc is low, so each rising-edge sample sees a settled value. The bench's PHY model updates mdio_i only on falling mdc edges. Its writes are one-cycle strobes driven on the falling system clock edge. It issues the writes that must be ignored only while a frame is running, and it always waits for bit 31 to clear before it starts the next access.

// File: rtl/mdio_acc_pkg.sv
package mdio_acc_pkg;

  // Layout of the software-visible access word
  typedef struct packed {
    logic        req;    // 31: request / acknowledge
    logic        wr;     // 30: 1 = write, 0 = read
    logic [3:0]  rsv;    // 29:26
    logic [4:0]  phy;    // 25:21
    logic [4:0]  regad;  // 20:16
    logic [15:0] data;   // 15:0
  } acc_word_t;

  localparam logic [1:0] ST_CODE  = 2'b01;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] TA_DRIVE = 2'b10;

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int CLK_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = $clog2(HALF) + 1;

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap     = run && (cnt == CW'(HALF - 1));
  assign rise_evt = wrap && !mdc;
  assign fall_evt = wrap && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
  import mdio_acc_pkg::*;
#(
  parameter int PREAMBLE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  acc_word_t   cmd,
  input  logic        rise_evt,
  input  logic        fall_evt,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        frame_done,
  output logic [15:0] rd_data
);
  localparam int FRAME_BITS = PREAMBLE_LEN + 32;
  localparam int IW         = $clog2(FRAME_BITS);
  localparam int TA_POS     = PREAMBLE_LEN + 14;
  localparam int DATA_POS   = PREAMBLE_LEN + 16;
  localparam int LAST       = FRAME_BITS - 1;

  logic [FRAME_BITS-1:0] frame_vec;
  logic [FRAME_BITS-1:0] sh;
  logic [IW-1:0]         idx;
  logic [IW-1:0]         idx_nxt;
  logic                  active;
  logic                  is_read;
  logic                  oe_q;
  logic [15:0]           rd_sh;

  always_comb begin
    frame_vec = {{PREAMBLE_LEN{1'b1}}, ST_CODE,
                 (cmd.wr ? OP_WRITE : OP_READ),
                 cmd.phy, cmd.regad, TA_DRIVE,
                 (cmd.wr ? cmd.data : 16'h0000)};
  end

  assign idx_nxt    = idx + 1'b1;
  assign frame_done = active && fall_evt && (idx == IW'(LAST));
  assign mdio_o     = sh[FRAME_BITS-1];
  assign mdio_oe    = oe_q;
  assign rd_data    = rd_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh      <= '1;
      idx     <= '0;
      active  <= 1'b0;
      is_read <= 1'b0;
      oe_q    <= 1'b0;
      rd_sh   <= '0;
    end else if (start) begin
      sh      <= frame_vec;
      idx     <= '0;
      active  <= 1'b1;
      is_read <= !cmd.wr;
      oe_q    <= 1'b1;
    end else if (active) begin
      if (rise_evt && is_read && (idx >= IW'(DATA_POS)))
        rd_sh <= {rd_sh[14:0], mdio_i};
      if (fall_evt) begin
        if (idx == IW'(LAST)) begin
          active <= 1'b0;
          oe_q   <= 1'b0;
        end else begin
          sh   <= {sh[FRAME_BITS-2:0], 1'b1};
          idx  <= idx_nxt;
          oe_q <= !(is_read && (idx_nxt >= IW'(TA_POS)));
        end
      end
    end
  end

endmodule

// File: rtl/mdio_acc_engine.sv
module mdio_acc_engine
  import mdio_acc_pkg::*;
#(
  parameter int CLK_DIV      = 8,
  parameter int PREAMBLE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  acc_word_t   acc;
  acc_word_t   wr_word;
  logic        accept;
  logic        start;
  logic        rise_evt;
  logic        fall_evt;
  logic        frame_done;
  logic [15:0] rd_data;

  assign wr_word   = acc_word_t'(reg_wdata);
  assign accept    = reg_wr && !acc.req;
  assign start     = accept && wr_word.req;
  assign reg_rdata = acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (accept) begin
      acc <= wr_word;
    end else if (frame_done) begin
      acc.req <= 1'b0;
      if (!acc.wr)
        acc.data <= rd_data;
    end
  end

  mdio_mdc_gen #(.CLK_DIV(CLK_DIV)) u_mdc (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (acc.req),
    .mdc      (mdc),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  mdio_frame_shifter #(.PREAMBLE_LEN(PREAMBLE_LEN)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cmd        (wr_word),
    .rise_evt   (rise_evt),
    .fall_evt   (fall_evt),
    .mdio_i     (mdio_i),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe),
    .frame_done (frame_done),
    .rd_data    (rd_data)
  );

endmodule

// File: rtl/mdio_acc_checker.sv
module mdio_acc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);

  AST_START_SETS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rdata[31] && reg_wr && reg_wdata[31]) |=> reg_rdata[31]); // R2

  AST_IDLE_WRITE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rdata[31] && reg_wr && !reg_wdata[31]) |=> !reg_rdata[31]); // R3

  AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R4

  AST_UPPER_KEPT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reg_rdata[31]) |-> $stable(reg_rdata[30:16])); // R6

  AST_BUSY_WORD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[31] && $past(reg_rdata[31])) |-> $stable(reg_rdata[30:0])); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[31] |-> (!mdc && !mdio_oe)); // R9

endmodule

bind mdio_acc_engine mdio_acc_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe)
);

// File: tb/mdio_acc_engine_bench.sv
module mdio_acc_engine_bench;
  localparam int CLK_DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        mdc;
  logic        mdio_o;
  logic        mdio_oe;
  logic        mdio_i;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  mdio_acc_engine #(.CLK_DIV(CLK_DIV), .PREAMBLE_LEN(32)) u_mdio_acc_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  // PHY model: capture on rising mdc, drive read data on falling mdc
  logic [63:0] cap_o;
  logic [63:0] cap_oe;
  logic [15:0] phy_rd;
  int rise_cnt = 0;
  int last_rise = 0;
  int period_c = 0;
  int high_c = 0;

  always @(posedge mdc) begin
    cap_o  = {cap_o[62:0], mdio_o};
    cap_oe = {cap_oe[62:0], mdio_oe};
    rise_cnt++;
    if (last_rise != 0) period_c = cyc - last_rise;
    last_rise = cyc;
  end

  always @(negedge mdc) begin
    high_c = cyc - last_rise;
    if (rise_cnt >= 48 && rise_cnt <= 63) mdio_i = phy_rd[63 - rise_cnt];
    else mdio_i = 1'b1;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [31:0] w);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_wdata = w;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic run_frame(input logic [31:0] w, input logic [15:0] rd, input bit poke);
    logic [63:0] exp;
    logic [31:0] exp_word;
    int n;
    phy_rd = rd;
    rise_cnt = 0;
    do_write(w);
    check(reg_rdata == w, "R2 word after start", {32'h0, reg_rdata}, {32'h0, w});
    if (poke) begin
      repeat (60) @(negedge clk);
      do_write(~w);
      check(reg_rdata == w, "R8 busy write ignored", {32'h0, reg_rdata}, {32'h0, w});
    end
    n = 0;
    while (reg_rdata[31] && n < 1000) begin
      @(negedge clk);
      n++;
    end
    check(!reg_rdata[31], "R7 request cleared", {63'h0, reg_rdata[31]}, 64'h0);
    check(rise_cnt == 64, "R4 bit count", 64'(rise_cnt), 64'd64);
    exp = {32'hFFFF_FFFF, 2'b01, (w[30] ? 2'b01 : 2'b10), w[25:21], w[20:16],
           2'b10, w[15:0]};
    if (w[30]) begin
      check(cap_o == exp, "R4 write frame", cap_o, exp);
      check(cap_oe == '1, "R4 write oe", cap_oe, '1);
      exp_word = {1'b0, w[30:0]};
      check(reg_rdata == exp_word, "R7 word after write", {32'h0, reg_rdata}, {32'h0, exp_word});
    end else begin
      check(cap_o[63:18] == exp[63:18], "R5 read header", {18'h0, cap_o[63:18]},
            {18'h0, exp[63:18]});
      check(cap_oe == {{46{1'b1}}, 18'h0}, "R5 read oe", cap_oe, {{46{1'b1}}, 18'h0});
      exp_word = {1'b0, w[30:16], rd};
      check(reg_rdata == exp_word, "R6 read result", {32'h0, reg_rdata}, {32'h0, exp_word});
    end
    check(!mdc && !mdio_oe, "R9 idle after frame", {62'h0, mdc, mdio_oe}, 64'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] w;
    logic [15:0] rd;
    logic [4:0] pa;
    logic [4:0] ra;
    rst_n = 1'b0;
    reg_wr = 1'b0;
    reg_wdata = '0;
    mdio_i = 1'b1;
    repeat (3) @(negedge clk);
    check(reg_rdata == 0 && !mdc && !mdio_oe, "R1 in reset",
          {31'h0, reg_rdata, mdc}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(reg_rdata == 0 && !mdc && !mdio_oe, "R1 after reset",
          {31'h0, reg_rdata, mdc}, 64'h0);

    // R3: idle write without request bit
    rise_cnt = 0;
    do_write(32'h4123_4567);
    check(reg_rdata == 32'h4123_4567, "R3 stored", {32'h0, reg_rdata}, 64'h4123_4567);
    repeat (40) @(negedge clk);
    check(rise_cnt == 0 && !mdc && !reg_rdata[31], "R3 no frame",
          64'(rise_cnt), 64'h0);

    // Example access: write 0x9000 to register 0 of PHY 5
    run_frame(32'hC0A0_9000, 16'h0000, 1'b0);
    check(period_c == CLK_DIV, "R9 mdc period", 64'(period_c), 64'(CLK_DIV));
    check(high_c == CLK_DIV / 2, "R9 mdc high phase", 64'(high_c), 64'(CLK_DIV / 2));

    // Sweep every PHY address with one write and one read frame
    for (int p = 0; p < 32; p++) begin
      pa = 5'(p);
      ra = 5'((p * 7 + 3) & 31);
      w = {1'b1, 1'b1, 4'b0, pa, ra, 16'((p * 16'h0841) ^ 16'hA5C3)};
      run_frame(w, 16'h0, p == 5);
      ra = 5'(31 - p);
      rd = 16'(p * 16'h1357 + 16'h2468);
      w = {1'b1, 1'b0, 4'b0, pa, ra, 16'h5A5A};
      run_frame(w, rd, p == 9);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule